// File: doc/BRIEF.md
# Dual-Slot Conditional-Access Card Bus Controller

This block lets a host reach two conditional-access card slots that share one card bus. The host sees a small bank of byte registers. Two of them hold a 14-bit card address, stored pre-shifted: the low register carries address bits 6:0 in its upper seven bits, and the high register carries bits 13:7 in its lower seven bits. A bus-control byte chooses the target slot and the address space (attribute memory or the control/IO space). It also starts per-slot card resets, turns on per-slot stream routing and shows per-slot card presence. A second control byte drives the two stream-output enables and the two active-low tuner reset lines.

An access to the data register starts one card bus cycle on the selected slot. A write drives the byte out. A read captures the byte the card returns. The host handshake signal `host_ready` pulses when the cycle ends. Every other register access completes one clock after the request.

A reset request holds the slot's card reset line for a parameterised number of clocks. It then waits for that card's ready signal. The request bit reads back as 1 for the whole time and clears itself at the end. Any change in a slot's presence sets a pending flag. The flag drives the interrupt line when the interrupt is enabled, and a read of the interrupt-control register clears it.

Three state machines carry the behaviour:
- **Host sequencer**
  - `H_IDLE` takes requests. An access to the data register is the *card start* transition to `H_CARD`.
  - `H_CARD` returns to `H_IDLE` on *card done*.
- **Card cycle engine**
  - `CY_IDLE` goes to `CY_SETUP` on *start*. `CY_SETUP` goes to `CY_STROBE` after one clock.
  - `CY_STROBE` goes to `CY_HOLD` on *strobe end*, which needs the minimum width elapsed and `card_wait` low.
  - `CY_HOLD` goes back to `CY_IDLE` after one clock and signals *done*.
- **Slot reset sequencer** (one per slot)
  - `RS_IDLE` goes to `RS_HOLD` on *request*.
  - `RS_HOLD` goes to `RS_WAIT` on *hold elapsed*.
  - `RS_WAIT` goes to `RS_IDLE` on *card ready*.

Top module: `ci_dual_slot_ctrl`

## Requirements
- R1: After reset, the outputs and registers take these values:
  - `host_ready`, `irq`, `card_rst`, `ts_route` and `ts_out_en` are 0.
  - `card_cs_n`, `card_rd_n` and `card_wr_n` are all high, and `tuner_rst_n` is 2'b11.
  - The interrupt-control register (offset 0) reads 0x00 and the output-control register (offset 1) reads 0x0C.
  - The address registers (offsets 2 and 3) read 0x00.
  - Bus control (offset 5) reads 0 in bits 7:2.
- R2: Addressing.
  - A write to offset 2 stores bits 7:1, and bit 0 always reads 0.
  - A write to offset 3 stores bits 6:0, and bit 7 always reads 0.
  - `card_addr` equals {offset3[6:0], offset2[7:1]}.
- R3: Bus-control bit 7 selects the slot: 0 asserts `card_cs_n[0]` low and 1 asserts `card_cs_n[1]` low. Bus-control bit 6 appears on `card_space` (1 = control/IO space, 0 = attribute memory).
- R4: A write to offset 4 runs a card write on the selected slot.
  - `card_wr_n` is low for exactly STROBE_CLKS clocks while `card_wait` is low.
  - `card_dout` carries the written byte and `card_oe` is high.
  - `host_ready` pulses at the end of the cycle.
- R5: A read of offset 4 runs a card read with `card_rd_n` low and returns the byte present on `card_din` at the end of the strobe on `host_rdata` with `host_ready`.
- R6: `card_wait` high during a strobe extends it. With `card_wait` high for the first W clocks of the strobe, the strobe lasts max(STROBE_CLKS, W+1) clocks.
- R7: Slot resets.
  - Writing 1 to bus-control bit 5 (slot 0) or bit 4 (slot 1) drives `card_rst` of that slot high for exactly RESET_CLKS clocks, then waits for `card_ready` of that slot.
  - The bit reads 1 until then and clears itself afterwards.
  - Writing 0 to the bit does not cancel a reset in progress.
- R8: Bus-control bit 3 drives `ts_route[0]` and bit 2 drives `ts_route[1]`. Both read back as written.
- R9: Bus-control bits 1 (slot 0) and 0 (slot 1) read the synchronised `card_det_n` level, where 0 means a card is present. Writes to these bits are ignored.
- R10: Output-control register (offset 1).
  - Bit 4 drives `ts_out_en[0]` and bit 5 drives `ts_out_en[1]`.
  - Bit 3 drives `tuner_rst_n[0]` and bit 2 drives `tuner_rst_n[1]`.
  - The whole byte reads back.
- R11: Presence interrupt.
  - Any change of a synchronised `card_det_n` bit sets the pending flag, which reads as bit 7 of offset 0.
  - `irq` equals pending AND offset-0 bit 0 (enable).
  - A read of offset 0 clears pending unless a new change arrives in the same clock.
- R12: A non-data register access raises `host_ready` for exactly one clock, one clock after `host_req`. Offsets 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, one clock |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_ready |
| host_ready | output | 1 | Access complete pulse |
| card_addr | output | 14 | Card address |
| card_dout | output | 8 | Byte driven to the card |
| card_din | input | 8 | Byte returned by the card |
| card_oe | output | 1 | Card data bus output enable |
| card_cs_n | output | 2 | Per-slot select, active low |
| card_space | output | 1 | 1 = control/IO space, 0 = attribute memory |
| card_rd_n | output | 1 | Read strobe, active low |
| card_wr_n | output | 1 | Write strobe, active low |
| card_wait | input | 1 | Card requests strobe extension |
| card_rst | output | 2 | Per-slot card reset, active high |
| card_ready | input | 2 | Per-slot card ready after reset |
| card_det_n | input | 2 | Per-slot presence, 0 = card present |
| ts_route | output | 2 | Per-slot stream routing enable |
| ts_out_en | output | 2 | Stream output enables |
| tuner_rst_n | output | 2 | Tuner resets, active low |
| irq | output | 1 | Presence-change interrupt |

## Verification
The assertions take for granted that the host issues no new request while a card cycle is in progress. The bench keeps to this because every access waits for `host_ready` before the next one starts.

The assertions also take `card_wait` and `card_ready` as synchronous to `clk`. The bench's card model drives both on the falling edge, so the reset-release and strobe-extension properties see clean levels.

Presence inputs change only on falling edges and are held for many clocks, so every change passes through the synchroniser as a single edge.

// File: rtl/ci_bus_pkg.sv
package ci_bus_pkg;

    localparam int HOST_AW = 3;
    localparam int BYTE_W  = 8;

    localparam logic [HOST_AW-1:0] OFF_IRQ   = 3'd0;
    localparam logic [HOST_AW-1:0] OFF_CTRL2 = 3'd1;
    localparam logic [HOST_AW-1:0] OFF_ALO   = 3'd2;
    localparam logic [HOST_AW-1:0] OFF_AHI   = 3'd3;
    localparam logic [HOST_AW-1:0] OFF_DATA  = 3'd4;
    localparam logic [HOST_AW-1:0] OFF_BUS   = 3'd5;

    // bus-control bit positions (decoded by software, keep fixed)
    localparam int BC_SLOT  = 7;
    localparam int BC_SPACE = 6;
    localparam int BC_RST0  = 5;
    localparam int BC_RST1  = 4;
    localparam int BC_TS0   = 3;
    localparam int BC_TS1   = 2;

    localparam logic [BYTE_W-1:0] CTRL2_RESET = 8'h0C;

    typedef enum logic [1:0] {
        CY_IDLE,
        CY_SETUP,
        CY_STROBE,
        CY_HOLD
    } cy_state_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HOLD,
        RS_WAIT
    } rs_state_t;

    typedef enum logic {
        H_IDLE,
        H_CARD
    } host_state_t;

endpackage

// File: rtl/ci_card_cycle.sv
module ci_card_cycle
    import ci_bus_pkg::*;
#(
    parameter int STROBE_CLKS = 4,
    parameter int CARD_AW     = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               we,
    input  logic               slot,
    input  logic               space,
    input  logic [CARD_AW-1:0] addr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [BYTE_W-1:0]  card_din,
    input  logic               card_wait,
    output logic [CARD_AW-1:0] card_addr,
    output logic [BYTE_W-1:0]  card_dout,
    output logic               card_oe,
    output logic [1:0]         card_cs_n,
    output logic               card_space,
    output logic               card_rd_n,
    output logic               card_wr_n,
    output logic               done,
    output logic [BYTE_W-1:0]  rdata
);

    localparam int CW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CLKS - 1);

    cy_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic          strobe_end;
    logic          active;

    assign strobe_end = (state == CY_STROBE) && (cnt == CNT_LAST) && !card_wait;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CY_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CY_IDLE:   if (start) nxt = CY_SETUP;
            CY_SETUP:  nxt = CY_STROBE;
            CY_STROBE: if (strobe_end) nxt = CY_HOLD;
            CY_HOLD:   nxt = CY_IDLE;
            default:   nxt = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            rdata <= '0;
        end else begin
            if (state != CY_STROBE)   cnt <= '0;
            else if (cnt != CNT_LAST) cnt <= cnt + 1'b1;
            if (strobe_end && !we)    rdata <= card_din;
        end
    end

    always_comb begin
        active     = (state != CY_IDLE);
        card_addr  = addr;
        card_dout  = wdata;
        card_space = space;
        card_oe    = active && we;
        card_cs_n  = active ? (slot ? 2'b01 : 2'b10) : 2'b11;
        card_rd_n  = !((state == CY_STROBE) && !we);
        card_wr_n  = !((state == CY_STROBE) && we);
        done       = (state == CY_HOLD);
    end

    a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~card_cs_n));
    a_r5_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_rd_n || !card_wr_n) |-> (card_cs_n != 2'b11));
    a_r4_strobe_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CY_STROBE && cnt != CNT_LAST) |=> (state == CY_STROBE));
    a_r6_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CY_STROBE && card_wait) |=> (state == CY_STROBE));

endmodule

// File: rtl/ci_slot_reset.sv
module ci_slot_reset
    import ci_bus_pkg::*;
#(
    parameter int RESET_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic card_ready,
    output logic card_rst,
    output logic busy
);

    localparam int CW = (RESET_CLKS > 1) ? $clog2(RESET_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RESET_CLKS - 1);

    rs_state_t     state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RS_IDLE: if (start) nxt = RS_HOLD;
            RS_HOLD: if (cnt == CNT_LAST) nxt = RS_WAIT;
            RS_WAIT: if (card_ready) nxt = RS_IDLE;
            default: nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (state != RS_HOLD)   cnt <= '0;
        else if (cnt != CNT_LAST)    cnt <= cnt + 1'b1;
    end

    always_comb begin
        card_rst = (state == RS_HOLD);
        busy     = (state != RS_IDLE);
    end

    a_r7_request_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> card_rst);
    a_r7_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_HOLD && cnt != CNT_LAST) |=> card_rst);
    a_r7_release_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(card_ready));

endmodule

// File: rtl/ci_presence_irq.sv
module ci_presence_irq
    import ci_bus_pkg::*;
#(
    parameter int SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] det_n,
    input  logic             clear,
    output logic [SLOTS-1:0] present_n,
    output logic             pending
);

    logic [SLOTS-1:0] sync1, sync2, prev;
    logic [SLOTS-1:0] change;

    assign change    = sync2 ^ prev;
    assign present_n = sync2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1   <= '1;
            sync2   <= '1;
            prev    <= '1;
            pending <= 1'b0;
        end else begin
            sync1 <= det_n;
            sync2 <= sync1;
            prev  <= sync2;
            if (|change)    pending <= 1'b1;
            else if (clear) pending <= 1'b0;
        end
    end

    a_r11_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|change) |=> pending);
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !(|change)) |=> !pending);

endmodule

// File: rtl/ci_dual_slot_ctrl.sv
module ci_dual_slot_ctrl
    import ci_bus_pkg::*;
#(
    parameter int STROBE_CLKS = 4,
    parameter int RESET_CLKS  = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_req,
    input  logic         host_we,
    input  logic [2:0]   host_addr,
    input  logic [7:0]   host_wdata,
    output logic [7:0]   host_rdata,
    output logic         host_ready,
    output logic [13:0]  card_addr,
    output logic [7:0]   card_dout,
    input  logic [7:0]   card_din,
    output logic         card_oe,
    output logic [1:0]   card_cs_n,
    output logic         card_space,
    output logic         card_rd_n,
    output logic         card_wr_n,
    input  logic         card_wait,
    output logic [1:0]   card_rst,
    input  logic [1:0]   card_ready,
    input  logic [1:0]   card_det_n,
    output logic [1:0]   ts_route,
    output logic [1:0]   ts_out_en,
    output logic [1:0]   tuner_rst_n,
    output logic         irq
);

    localparam int SLOTS   = 2;
    localparam int LO_BITS = BYTE_W - 1;
    localparam int CARD_AW = 2 * LO_BITS;

    host_state_t        hst, hst_nxt;
    logic [LO_BITS-1:0] alo;
    logic [LO_BITS-1:0] ahi;
    logic [BYTE_W-1:0]  dreg;
    logic [BYTE_W-1:0]  ctrl2;
    logic               bc_slot, bc_space;
    logic [SLOTS-1:0]   bc_ts;
    logic               irq_en;
    logic               cur_we;

    logic               acc, wr_en, rd_en;
    logic               cy_start, cy_done;
    logic [BYTE_W-1:0]  cy_rdata;
    logic [SLOTS-1:0]   rs_start, rs_busy;
    logic [SLOTS-1:0]   pres_n;
    logic               pending, irq_clear;
    logic [BYTE_W-1:0]  busctl_rd, reg_rd;

    // request decode
    always_comb begin
        acc       = host_req && (hst == H_IDLE);
        wr_en     = acc && host_we;
        rd_en     = acc && !host_we;
        cy_start  = acc && (host_addr == OFF_DATA);
        irq_clear = rd_en && (host_addr == OFF_IRQ);
        rs_start[0] = wr_en && (host_addr == OFF_BUS) && host_wdata[BC_RST0];
        rs_start[1] = wr_en && (host_addr == OFF_BUS) && host_wdata[BC_RST1];
    end

    // host sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) hst <= H_IDLE;
        else        hst <= hst_nxt;
    end

    always_comb begin
        hst_nxt = hst;
        unique case (hst)
            H_IDLE:  if (cy_start) hst_nxt = H_CARD;
            H_CARD:  if (cy_done)  hst_nxt = H_IDLE;
            default: hst_nxt = H_IDLE;
        endcase
    end

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alo      <= '0;
            ahi      <= '0;
            dreg     <= '0;
            ctrl2    <= CTRL2_RESET;
            bc_slot  <= 1'b0;
            bc_space <= 1'b0;
            bc_ts    <= '0;
            irq_en   <= 1'b0;
            cur_we   <= 1'b0;
        end else begin
            if (wr_en) begin
                case (host_addr)
                    OFF_IRQ:   irq_en <= host_wdata[0];
                    OFF_CTRL2: ctrl2  <= host_wdata;
                    OFF_ALO:   alo    <= host_wdata[BYTE_W-1:1];
                    OFF_AHI:   ahi    <= host_wdata[LO_BITS-1:0];
                    OFF_DATA:  dreg   <= host_wdata;
                    OFF_BUS: begin
                        bc_slot  <= host_wdata[BC_SLOT];
                        bc_space <= host_wdata[BC_SPACE];
                        bc_ts[0] <= host_wdata[BC_TS0];
                        bc_ts[1] <= host_wdata[BC_TS1];
                    end
                    default: ;
                endcase
            end
            if (cy_start) cur_we <= host_we;
            if ((hst == H_CARD) && cy_done && !cur_we) dreg <= cy_rdata;
        end
    end

    // read data
    always_comb begin
        busctl_rd = {bc_slot, bc_space, rs_busy[0], rs_busy[1],
                     bc_ts[0], bc_ts[1], pres_n[0], pres_n[1]};
        case (host_addr)
            OFF_IRQ:   reg_rd = {pending, 6'b0, irq_en};
            OFF_CTRL2: reg_rd = ctrl2;
            OFF_ALO:   reg_rd = {alo, 1'b0};
            OFF_AHI:   reg_rd = {1'b0, ahi};
            OFF_DATA:  reg_rd = dreg;
            OFF_BUS:   reg_rd = busctl_rd;
            default:   reg_rd = '0;
        endcase
    end

    // host response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ready <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ready <= 1'b0;
            if (acc && !cy_start) begin
                host_ready <= 1'b1;
                host_rdata <= reg_rd;
            end else if ((hst == H_CARD) && cy_done) begin
                host_ready <= 1'b1;
                host_rdata <= cur_we ? dreg : cy_rdata;
            end
        end
    end

    // card cycle engine
    ci_card_cycle #(
        .STROBE_CLKS (STROBE_CLKS),
        .CARD_AW     (CARD_AW)
    ) u_cycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cy_start),
        .we         (cur_we),
        .slot       (bc_slot),
        .space      (bc_space),
        .addr       ({ahi, alo}),
        .wdata      (dreg),
        .card_din   (card_din),
        .card_wait  (card_wait),
        .card_addr  (card_addr),
        .card_dout  (card_dout),
        .card_oe    (card_oe),
        .card_cs_n  (card_cs_n),
        .card_space (card_space),
        .card_rd_n  (card_rd_n),
        .card_wr_n  (card_wr_n),
        .done       (cy_done),
        .rdata      (cy_rdata)
    );

    // per-slot reset sequencers
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot_rst
        ci_slot_reset #(
            .RESET_CLKS (RESET_CLKS)
        ) u_rst (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (rs_start[s]),
            .card_ready (card_ready[s]),
            .card_rst   (card_rst[s]),
            .busy       (rs_busy[s])
        );
    end

    ci_presence_irq #(
        .SLOTS (SLOTS)
    ) u_pres (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_n     (card_det_n),
        .clear     (irq_clear),
        .present_n (pres_n),
        .pending   (pending)
    );

    always_comb begin
        ts_route       = bc_ts;
        ts_out_en[0]   = ctrl2[4];
        ts_out_en[1]   = ctrl2[5];
        tuner_rst_n[0] = ctrl2[3];
        tuner_rst_n[1] = ctrl2[2];
        irq            = pending && irq_en;
    end

    a_r12_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);
    a_r12_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && host_addr != OFF_DATA) |=> host_ready);
    a_r4_card_busy_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (hst == H_CARD) |-> (card_cs_n != 2'b11));
    a_r3_slot_match: assert property (@(posedge clk) disable iff (!rst_n)
        (card_cs_n != 2'b11) |-> (card_cs_n[bc_slot] == 1'b0));

endmodule

// File: tb/ci_dual_slot_ctrl_tb.sv
`timescale 1ns/1ps
module ci_dual_slot_ctrl_tb;

    localparam int STROBE = 4;
    localparam int RSTC   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ready;
    logic [13:0] card_addr;
    logic [7:0]  card_dout, card_din;
    logic        card_oe, card_space, card_rd_n, card_wr_n;
    logic [1:0]  card_cs_n, card_rst, ts_route, ts_out_en, tuner_rst_n;
    logic        card_wait = 1'b0;
    logic [1:0]  card_ready = 2'b11;
    logic [1:0]  card_det_n = 2'b11;
    logic        irq;

    int checks = 0, fails = 0;
    int wait_req = 0, wcnt = 0, slen = 0, last_len = 0;
    logic [7:0]  cmem [0:255];
    logic [13:0] w_addr;
    logic [7:0]  w_data;
    logic        w_slot, w_space, w_oe;
    logic [7:0]  midx;

    always #2.5 clk = ~clk;

    ci_dual_slot_ctrl #(.STROBE_CLKS(STROBE), .RESET_CLKS(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .card_addr(card_addr), .card_dout(card_dout),
        .card_din(card_din), .card_oe(card_oe), .card_cs_n(card_cs_n),
        .card_space(card_space), .card_rd_n(card_rd_n), .card_wr_n(card_wr_n),
        .card_wait(card_wait), .card_rst(card_rst), .card_ready(card_ready),
        .card_det_n(card_det_n), .ts_route(ts_route), .ts_out_en(ts_out_en),
        .tuner_rst_n(tuner_rst_n), .irq(irq)
    );

    // card model
    assign midx    = {~card_cs_n[1], card_space, card_addr[5:0]};
    assign card_din = card_rd_n ? 8'h00 : cmem[midx];

    always @(negedge clk) begin
        if (!card_wr_n) begin
            cmem[midx] <= card_dout;
            w_addr  <= card_addr;
            w_data  <= card_dout;
            w_slot  <= ~card_cs_n[1];
            w_space <= card_space;
            w_oe    <= card_oe;
        end
        if (!card_rd_n || !card_wr_n) slen <= slen + 1;
        else if (slen != 0) begin last_len <= slen; slen <= 0; end
        if (!card_rd_n && wcnt < wait_req) begin
            card_wait <= 1'b1; wcnt <= wcnt + 1;
        end else begin
            card_wait <= 1'b0;
            if (card_rd_n) wcnt <= 0;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        lat = 0;
        while (!host_ready && lat < 1000) begin @(negedge clk); lat++; end
        q = host_rdata;
    endtask

    task automatic set_addr(input logic [13:0] a);
        logic [7:0] q; int l;
        xfer(1'b1, 3'd2, {a[6:0], 1'b0}, q, l);
        xfer(1'b1, 3'd3, {1'b0, a[13:7]}, q, l);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] q; int lat; int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {host_ready, irq, card_rst, ts_route, ts_out_en},
            {1'b0, 1'b0, 2'b00, 2'b00, 2'b00});
        chk("R1 strobes", {card_cs_n, card_rd_n, card_wr_n, tuner_rst_n},
            {2'b11, 1'b1, 1'b1, 2'b11});
        xfer(1'b0, 3'd5, 8'h00, q, lat); chk("R1 busctl", q, 8'h03);
        chk("R12 latency", lat, 0);
        xfer(1'b0, 3'd1, 8'h00, q, lat); chk("R1 ctrl2", q, 8'h0C);
        xfer(1'b0, 3'd0, 8'h00, q, lat); chk("R1 irqctl", q, 8'h00);
        xfer(1'b0, 3'd2, 8'h00, q, lat); chk("R1 addr lo", q, 8'h00);
        @(negedge clk);
        chk("R12 single pulse", host_ready, 1'b0);

        // R2 address packing
        xfer(1'b1, 3'd2, 8'hFF, q, lat); xfer(1'b0, 3'd2, 8'h00, q, lat);
        chk("R2 lo bit0 zero", q, 8'hFE);
        xfer(1'b1, 3'd3, 8'hFF, q, lat); xfer(1'b0, 3'd3, 8'h00, q, lat);
        chk("R2 hi bit7 zero", q, 8'h7F);
        chk("R2 card_addr", card_addr, 14'h3FFF);
        xfer(1'b1, 3'd6, 8'h55, q, lat); xfer(1'b0, 3'd6, 8'h00, q, lat);
        chk("R12 unmapped", q, 8'h00);

        // R10 output control
        xfer(1'b1, 3'd1, 8'h30, q, lat);
        chk("R10 ctrl 30", {ts_out_en, tuner_rst_n}, {2'b11, 2'b00});
        xfer(1'b1, 3'd1, 8'h14, q, lat);
        chk("R10 ctrl 14", {ts_out_en, tuner_rst_n}, {2'b01, 2'b10});
        xfer(1'b0, 3'd1, 8'h00, q, lat); chk("R10 readback", q, 8'h14);
        xfer(1'b1, 3'd1, 8'h0C, q, lat);

        // R3 R4 R5 sweep over slot, space and every address bit
        for (int s = 0; s < 2; s++) begin
            for (int sp = 0; sp < 2; sp++) begin
                xfer(1'b1, 3'd5, {s[0], sp[0], 6'b0}, q, lat);
                for (int i = 0; i < 14; i++) begin
                    logic [13:0] a;
                    logic [7:0]  d;
                    a = 14'(1 << i) ^ 14'(i);
                    d = 8'((s * 64) + (sp * 32) + (i * 5) + 17);
                    set_addr(a);
                    xfer(1'b1, 3'd4, d, q, lat);
                    chk("R3/R4 write slot space addr data",
                        {w_slot, w_space, w_addr, w_data, w_oe},
                        {s[0], sp[0], a, d, 1'b1});
                    xfer(1'b0, 3'd4, 8'h00, q, lat);
                    chk("R5 read data", q, d);
                end
            end
        end

        // R4 strobe width and R6 wait extension
        set_addr(14'h0021);
        xfer(1'b1, 3'd4, 8'hA5, q, lat);
        chk("R4 strobe width", last_len, STROBE);
        wait_req = 6;
        xfer(1'b0, 3'd4, 8'h00, q, lat);
        chk("R6 stretched width", last_len, 7);
        chk("R6 data", q, 8'hA5);
        wait_req = 2;
        xfer(1'b0, 3'd4, 8'h00, q, lat);
        chk("R6 short wait width", last_len, STROBE);
        wait_req = 0;

        // R8 stream routing
        xfer(1'b1, 3'd5, 8'h0C, q, lat);
        chk("R8 both", ts_route, 2'b11);
        xfer(1'b1, 3'd5, 8'h08, q, lat);
        chk("R8 slot0 only", ts_route, 2'b01);
        xfer(1'b0, 3'd5, 8'h00, q, lat); chk("R8 readback", q, 8'h0B);
        xfer(1'b1, 3'd5, 8'h00, q, lat);

        // R7 slot 0 reset
        card_ready = 2'b10;
        xfer(1'b1, 3'd5, 8'h20, q, lat);
        cnt = 0;
        while (card_rst[0] && cnt < 100) begin cnt++; @(negedge clk); end
        chk("R7 slot0 hold", cnt, RSTC);
        chk("R7 slot1 quiet", card_rst[1], 1'b0);
        xfer(1'b1, 3'd5, 8'h00, q, lat);
        xfer(1'b0, 3'd5, 8'h00, q, lat); chk("R7 busy while waiting", q, 8'h23);
        card_ready = 2'b11;
        repeat (3) @(negedge clk);
        xfer(1'b0, 3'd5, 8'h00, q, lat); chk("R7 self clear", q, 8'h03);
        // slot 1
        card_ready = 2'b01;
        xfer(1'b1, 3'd5, 8'h10, q, lat);
        cnt = 0;
        while (card_rst[1] && cnt < 100) begin cnt++; @(negedge clk); end
        chk("R7 slot1 hold", cnt, RSTC);
        xfer(1'b0, 3'd5, 8'h00, q, lat); chk("R7 slot1 busy", q, 8'h13);
        card_ready = 2'b11;
        repeat (3) @(negedge clk);
        xfer(1'b0, 3'd5, 8'h00, q, lat); chk("R7 slot1 clear", q, 8'h03);

        // R9 R11 presence and interrupt
        card_det_n = 2'b10;
        repeat (6) @(negedge clk);
        chk("R11 irq masked", irq, 1'b0);
        xfer(1'b0, 3'd5, 8'h00, q, lat); chk("R9 slot0 present", q, 8'h01);
        xfer(1'b0, 3'd0, 8'h00, q, lat); chk("R11 pending", q, 8'h80);
        xfer(1'b0, 3'd0, 8'h00, q, lat); chk("R11 cleared", q, 8'h00);
        xfer(1'b1, 3'd0, 8'h01, q, lat);
        card_det_n = 2'b00;
        repeat (6) @(negedge clk);
        chk("R11 irq raised", irq, 1'b1);
        xfer(1'b1, 3'd5, 8'h03, q, lat);
        xfer(1'b0, 3'd5, 8'h00, q, lat); chk("R9 writes ignored", q, 8'h00);
        xfer(1'b0, 3'd0, 8'h00, q, lat); chk("R11 pending enabled", q, 8'h81);
        @(negedge clk);
        chk("R11 irq dropped", irq, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule